// File: doc/BRIEF.md
# Synchronizable Timer Counter Bank

A bank of six 16-bit up-counters behind one small register bus. Each channel has a counter, a compare register, a control register and one output pin. A global run register starts or stops each counter with one bit per channel. A global group register lets any set of channels be bound together. Once two or more channels are bound, a software write to any bound counter loads the same value into every bound counter in the same cycle. A clear event on one bound channel can also reset the other bound channels at the same clock edge.

Each channel's control register picks a clear source and an initial pin level. The pin toggles whenever a running counter equals its compare value. Stopping a channel freezes its pin where it is. Rewriting the control register while the channel is stopped forces the pin to the programmed initial level. The block runs from one clock. Its reset is active-low and asynchronous on assertion. The block synchronizes the release of reset internally, so the first usable bus cycle is the third clock edge after the reset input goes high.

Top module: `sync_timer_bank`

## Requirements
- R1: While reset is held and after it is released, every readable register reads 0 and all output pins are 0.
- R2: Run register (address 24), bit i for channel i: 1 makes that counter advance by one each clock, 0 holds it at its value. The counter wraps from 0xFFFF to 0.
- R3: Group register (address 25): bits 5..0 are read/write, one per channel, and bits 15..6 always read 0.
- R4: Channels are grouped only when at least two group bits are set. With a single set bit, that channel behaves exactly like an ungrouped one.
- R5: A counter write to a grouped channel loads the written value into every grouped counter at the same edge. A counter write to an ungrouped channel loads only that counter.
- R6: Clear-source code 001 (control bits 2..0): when a running counter equals its compare value, it becomes 0 at the next edge instead of incrementing.
- R7: Clear-source code 011 on a grouped channel: its counter becomes 0 at the same edge where any grouped channel performs a code-001 clear. Every code other than 001 and 011 never clears.
- R8: Priority, per counter, in one cycle: group clear first, then a software counter write, then the own clear or the increment.
- R9: A running channel's pin inverts at the edge after any cycle in which its counter equals its compare value.
- R10: A stopped channel's pin keeps its level, including the level it had when it was stopped.
- R11: Writing a channel's control register while its run bit is 0 sets its pin to control bit 3 at the same edge. The same write while the channel runs leaves the pin to R9.
- R12: Map: channel k uses address 4k+0 for the counter, 4k+1 for compare, and 4k+2 for control (bits 3..0). Read data appears one cycle after the address. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the address |
| tmr_out | output | 6 | Per-channel compare output pins |

## Verification
The assertions assume one register access per cycle on a bus that holds valid levels at every edge. They also assume that a clear event is only raised by a channel that is running. The stimulus keeps compare values and counter preloads small, so matches, own clears and group clears occur often. It draws group masks that include empty, single-bit and multi-bit cases. It also steers directed sequences so that a counter write lands exactly on a group clear cycle.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int CCS_W = 3;
  localparam logic [CCS_W-1:0] CCS_NONE = 3'b000;
  localparam logic [CCS_W-1:0] CCS_OWN  = 3'b001;
  localparam logic [CCS_W-1:0] CCS_GRP  = 3'b011;
  localparam int OFF_CNT = 0;
  localparam int OFF_CMP = 1;
  localparam int OFF_CTL = 2;
  localparam int CH_STRIDE = 4;
  localparam int CTL_INIT_BIT = 3;
endpackage

// File: rtl/stb_channel.sv
module stb_channel
  import stb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic             sclr_i,
  input  logic             cmp_we_i,
  input  logic             ctl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CCS_W-1:0] ccs_o,
  output logic             init_o,
  output logic             own_clr_o,
  output logic             pin_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q;
  logic [CCS_W-1:0] ccs_q;
  logic             init_q, pin_q, pin_d;
  logic             cnt_en, pin_en, match;

  assign match     = run_i && (cnt_q == cmp_q);
  assign own_clr_o = match && (ccs_q == CCS_OWN);

  always_comb begin
    cnt_en = sclr_i || ld_i || own_clr_o || run_i;
    if (sclr_i)         cnt_d = '0;
    else if (ld_i)      cnt_d = wdata_i;
    else if (own_clr_o) cnt_d = '0;
    else                cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    pin_en = (ctl_we_i && !run_i) || match;
    if (ctl_we_i && !run_i) pin_d = wdata_i[CTL_INIT_BIT];
    else                    pin_d = !pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      ccs_q  <= '0;
      init_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q <= cnt_d;
      if (cmp_we_i) cmp_q <= wdata_i;
      if (ctl_we_i) begin
        ccs_q  <= wdata_i[CCS_W-1:0];
        init_q <= wdata_i[CTL_INIT_BIT];
      end
      if (pin_en)   pin_q <= pin_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign ccs_o  = ccs_q;
  assign init_o = init_q;
  assign pin_o  = pin_q;

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ld_i && !sclr_i) |=> $stable(cnt_q));
  // R7
  group_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclr_i |=> (cnt_q == '0));
  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !sclr_i) |=> (cnt_q == $past(wdata_i)));
  // R10
  stopped_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ctl_we_i) |=> $stable(pin_q));
endmodule

// File: rtl/stb_group.sv
module stb_group #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] grp_sel_i,
  input  logic [NUM_CH-1:0] grp_ccs_i,
  input  logic [NUM_CH-1:0] own_clr_i,
  input  logic [NUM_CH-1:0] cnt_wr_i,
  output logic [NUM_CH-1:0] ld_o,
  output logic [NUM_CH-1:0] sclr_o
);
  localparam int NW = $clog2(NUM_CH + 1);

  logic [NW-1:0]     n_sel;
  logic              grp_ok, any_src, any_wr;
  logic [NUM_CH-1:0] member;

  always_comb begin
    n_sel = '0;
    for (int i = 0; i < NUM_CH; i++) n_sel = n_sel + NW'(grp_sel_i[i]);
  end

  assign grp_ok  = (n_sel >= NW'(2));
  assign member  = grp_ok ? grp_sel_i : '0;
  assign any_src = |(member & own_clr_i);
  assign any_wr  = |(member & cnt_wr_i);
  assign sclr_o  = member & grp_ccs_i & {NUM_CH{any_src}};
  assign ld_o    = cnt_wr_i | (member & {NUM_CH{any_wr}});

  // R4
  group_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sclr_o) || ((ld_o & ~cnt_wr_i) != '0)) |-> ($countones(grp_sel_i) >= 2));
  // R7
  clear_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sclr_o) |-> ((own_clr_i & grp_sel_i) != '0));
endmodule

// File: rtl/sync_timer_bank.sv
module sync_timer_bank
  import stb_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] tmr_out
);
  localparam int RUN_ADDR = NUM_CH * CH_STRIDE;
  localparam int GRP_ADDR = RUN_ADDR + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [NUM_CH-1:0] run_q, grp_q;
  logic [CNT_W-1:0]  rdata_q, rdata_d;
  logic              run_we, grp_we;
  logic [NUM_CH-1:0] cnt_wr, cmp_we, ctl_we, ld, sclr, own_clr, grp_ccs, pin;
  logic [CNT_W-1:0]  cnt [NUM_CH];
  logic [CNT_W-1:0]  cmpv [NUM_CH];
  logic [CCS_W-1:0]  ccs [NUM_CH];
  logic [NUM_CH-1:0] init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cnt_wr[i]  = bus_we && (bus_addr == ADDR_W'(i * CH_STRIDE + OFF_CNT));
      cmp_we[i]  = bus_we && (bus_addr == ADDR_W'(i * CH_STRIDE + OFF_CMP));
      ctl_we[i]  = bus_we && (bus_addr == ADDR_W'(i * CH_STRIDE + OFF_CTL));
      grp_ccs[i] = (ccs[i] == CCS_GRP);
    end
    run_we = bus_we && (bus_addr == ADDR_W'(RUN_ADDR));
    grp_we = bus_we && (bus_addr == ADDR_W'(GRP_ADDR));
  end

  stb_group #(.NUM_CH(NUM_CH)) u_group (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .grp_sel_i (grp_q),
    .grp_ccs_i (grp_ccs),
    .own_clr_i (own_clr),
    .cnt_wr_i  (cnt_wr),
    .ld_o      (ld),
    .sclr_o    (sclr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    stb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .run_i     (run_q[g]),
      .ld_i      (ld[g]),
      .sclr_i    (sclr[g]),
      .cmp_we_i  (cmp_we[g]),
      .ctl_we_i  (ctl_we[g]),
      .wdata_i   (bus_wdata),
      .cnt_o     (cnt[g]),
      .cmp_o     (cmpv[g]),
      .ccs_o     (ccs[g]),
      .init_o    (init[g]),
      .own_clr_o (own_clr[g]),
      .pin_o     (pin[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i * CH_STRIDE + OFF_CNT)) rdata_d = cnt[i];
      if (bus_addr == ADDR_W'(i * CH_STRIDE + OFF_CMP)) rdata_d = cmpv[i];
      if (bus_addr == ADDR_W'(i * CH_STRIDE + OFF_CTL))
        rdata_d = CNT_W'({init[i], ccs[i]});
    end
    if (bus_addr == ADDR_W'(RUN_ADDR)) rdata_d = CNT_W'(run_q);
    if (bus_addr == ADDR_W'(GRP_ADDR)) rdata_d = CNT_W'(grp_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q   <= '0;
      grp_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (run_we) run_q <= bus_wdata[NUM_CH-1:0];
      if (grp_we) grp_q <= bus_wdata[NUM_CH-1:0];
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign tmr_out   = pin;

  // R3
  grp_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_addr == ADDR_W'(GRP_ADDR)) |=> (bus_rdata[CNT_W-1:NUM_CH] == '0));
  // R12
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_addr > ADDR_W'(GRP_ADDR)) |=> (bus_rdata == '0));
endmodule

// File: tb/sync_timer_bank_bench.sv
module sync_timer_bank_bench;
  localparam int N = 6;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [N-1:0] tmr_out;
  int checks = 0;
  int errors = 0;

  logic [15:0] m_cnt [N];
  logic [15:0] m_cmp [N];
  logic [3:0]  m_ctl [N];
  logic [N-1:0] m_out, m_run, m_grp;

  always #4 clk = !clk;

  sync_timer_bank u_sync_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_out(tmr_out));

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [4:0] a);
    int k = int'(a) / 4;
    int o = int'(a) % 4;
    if (a < 5'd24) begin
      if (o == 0) return m_cnt[k];
      if (o == 1) return m_cmp[k];
      if (o == 2) return {12'h000, m_ctl[k]};
      return 16'h0;
    end
    if (a == 5'd24) return {10'h0, m_run};
    if (a == 5'd25) return {10'h0, m_grp};
    return 16'h0;
  endfunction

  task automatic model_step(input logic [4:0] a, input logic w, input logic [15:0] d);
    int n = $countones(m_grp);
    logic [N-1:0] mem, match, own;
    logic any_src, any_wr;
    int k = int'(a) / 4;
    int o = int'(a) % 4;
    logic [15:0] nc [N];
    mem = (n >= 2) ? m_grp : '0;
    any_src = 1'b0;
    any_wr = w && a < 5'd24 && o == 0 && mem[k];
    for (int i = 0; i < N; i++) begin
      match[i] = m_run[i] && (m_cnt[i] == m_cmp[i]);
      own[i] = match[i] && (m_ctl[i][2:0] == 3'b001);
      if (mem[i] && own[i]) any_src = 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      logic sc, ld;
      sc = mem[i] && (m_ctl[i][2:0] == 3'b011) && any_src;
      ld = (w && a < 5'd24 && o == 0 && k == i) || (any_wr && mem[i]);
      if (sc) nc[i] = 16'h0;
      else if (ld) nc[i] = d;
      else if (own[i]) nc[i] = 16'h0;
      else if (m_run[i]) nc[i] = m_cnt[i] + 16'h1;
      else nc[i] = m_cnt[i];
      if (w && a < 5'd24 && o == 2 && k == i && !m_run[i]) m_out[i] = d[3];
      else if (match[i]) m_out[i] = !m_out[i];
    end
    for (int i = 0; i < N; i++) m_cnt[i] = nc[i];
    if (w && a < 5'd24 && k < N && o == 1) m_cmp[k] = d;
    if (w && a < 5'd24 && k < N && o == 2) m_ctl[k] = d[3:0];
    if (w && a == 5'd24) m_run = d[5:0];
    if (w && a == 5'd25) m_grp = d[5:0];
  endtask

  task automatic tick(input logic [4:0] a, input logic w, input logic [15:0] d, input string tag);
    logic [15:0] exp_rd;
    bus_addr = a; bus_we = w; bus_wdata = d;
    exp_rd = mread(a);
    model_step(a, w, d);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    chk({tag, " rdata"}, bus_rdata, exp_rd);
    chk({tag, " pins"}, {10'h0, tmr_out}, {10'h0, m_out});
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
    tick(a, 1'b1, d, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(5'd31, 1'b0, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = '0; m_cmp[i] = '0; m_ctl[i] = '0;
    end
    m_out = '0; m_run = '0; m_grp = '0;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", {10'h0, tmr_out}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    tick(5'd24, 1'b0, 16'h0, "R1");
    tick(5'd25, 1'b0, 16'h0, "R1");
    tick(5'd0, 1'b0, 16'h0, "R1");
    tick(5'd22, 1'b0, 16'h0, "R1");
    // R3: group register width
    wr(5'd25, 16'hFFFF, "R3");
    tick(5'd25, 1'b0, 16'h0, "R3");
    wr(5'd25, 16'h0000, "R3");
    // R2: run and stop, plus wrap
    wr(5'd0, 16'hFFFD, "R2");
    wr(5'd24, 16'h0001, "R2");
    idle(4, "R2");
    tick(5'd0, 1'b0, 16'h0, "R2");
    wr(5'd24, 16'h0000, "R2");
    idle(2, "R2");
    tick(5'd0, 1'b0, 16'h0, "R2");
    // R4: single group bit is not a group
    wr(5'd25, 16'h0002, "R4");
    wr(5'd4, 16'd100, "R4");
    tick(5'd8, 1'b0, 16'h0, "R4");
    tick(5'd4, 1'b0, 16'h0, "R4");
    // R5: group preset
    wr(5'd25, 16'h000E, "R5");
    wr(5'd8, 16'd500, "R5");
    tick(5'd4, 1'b0, 16'h0, "R5");
    tick(5'd12, 1'b0, 16'h0, "R5");
    tick(5'd16, 1'b0, 16'h0, "R5");
    wr(5'd16, 16'd9, "R5");
    tick(5'd8, 1'b0, 16'h0, "R5");
    // R11: control write while stopped sets pin
    wr(5'd10, 16'h0008, "R11");
    wr(5'd6, 16'h0008, "R11");
    // R6: own clear on compare
    wr(5'd1, 16'd3, "R6");
    wr(5'd2, 16'h0001, "R6");
    wr(5'd0, 16'd0, "R6");
    wr(5'd24, 16'h0001, "R6");
    idle(5, "R6 R9");
    tick(5'd0, 1'b0, 16'h0, "R6");
    // R10: stop keeps pin
    wr(5'd24, 16'h0000, "R10");
    idle(3, "R10");
    // R11: control write while running leaves pin
    wr(5'd24, 16'h0004, "R11");
    wr(5'd10, 16'h0000, "R11");
    idle(2, "R11");
    // R7: group clear with code 011 and code 000 bystander
    wr(5'd24, 16'h0000, "R7");
    wr(5'd25, 16'h0007, "R7");
    wr(5'd6, 16'h0003, "R7");
    wr(5'd10, 16'h0000, "R7");
    wr(5'd1, 16'd4, "R7");
    wr(5'd2, 16'h0001, "R7");
    wr(5'd0, 16'd0, "R7");
    wr(5'd24, 16'h0007, "R7");
    idle(5, "R7");
    tick(5'd4, 1'b0, 16'h0, "R7");
    tick(5'd8, 1'b0, 16'h0, "R7");
    // R8: counter write collides with group clear
    for (int i = 0; i < 20 && m_cnt[0] != m_cmp[0]; i++) tick(5'd31, 1'b0, 16'h0, "R8");
    wr(5'd4, 16'h0777, "R8");
    tick(5'd4, 1'b0, 16'h0, "R8");
    for (int i = 0; i < 20 && m_cnt[0] != m_cmp[0]; i++) tick(5'd31, 1'b0, 16'h0, "R8");
    wr(5'd0, 16'h0123, "R8");
    tick(5'd0, 1'b0, 16'h0, "R8");
    // R12: map and unmapped addresses
    tick(5'd3, 1'b0, 16'h0, "R12");
    tick(5'd30, 1'b0, 16'h0, "R12");
    // Random mix, checked every cycle against the model
    for (int it = 0; it < 4000; it++) begin
      int sel = int'($urandom % 10);
      int ch = int'($urandom % N);
      logic [4:0] base = 5'(ch * 4);
      logic [2:0] cc;
      case ($urandom % 4)
        0: cc = 3'b000;
        1: cc = 3'b001;
        2: cc = 3'b011;
        default: cc = 3'($urandom);
      endcase
      case (sel)
        0: wr(base, 16'($urandom % 24), "R9 R5");
        1: wr(base + 5'd1, 16'($urandom % 20), "R9 R6");
        2: wr(base + 5'd2, {12'h0, 1'($urandom), cc}, "R9 R11");
        3: wr(5'd24, 16'($urandom), "R9 R2");
        4: if ($urandom % 3 == 0) wr(5'd25, 16'($urandom), "R9 R4");
           else tick(5'($urandom), 1'b0, 16'h0, "R9 R12");
        default: tick(5'($urandom), 1'b0, 16'h0, "R9 R7 R8");
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule